// File: doc/BRIEF.md
# Skip-Pattern Three-Bit Sequence Counter

This block is a synchronous state machine that walks a fixed, non-contiguous cycle of three-bit values: 1, 3, 4, 5, 7, then back to 1. The values 0, 2 and 6 are never part of the cycle. The state is held in one D-type flip-flop per bit. The state encoding is the output value itself, so the count output comes straight from the flip-flops with no decoding stage after them.

A count enable decides whether a rising clock edge advances the state one step or keeps it where it is. A synchronous active-high reset puts the state at 1, the first value of the cycle. A synchronous preset port writes any three-bit code, including an unused one, into the register. This gives the counter a known starting point, and it lets a test place the counter in 0, 2 or 6. Each unused code leads to a cycle member on the next advancing edge, so an upset state recovers within one step. The output is a plain level, not a stream. It has no valid/ready handshake because a value is always present and nothing downstream can stall it.

Top module: `seq_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next value of `count` is 1, whatever the other inputs are doing.
- R2: With `rst` and `load_en` low and `cnt_en` high, each rising edge moves `count` one step along 1 to 3, 3 to 4, 4 to 5 and 5 to 7.
- R3: With `cnt_en` high and `count` equal to 7, the next edge gives 1, and the cycle repeats indefinitely.
- R4: With `rst`, `load_en` and `cnt_en` all low, `count` keeps its value across clock edges.
- R5: When the counter advances from an unused code, it goes to a cycle member on that edge: 0 goes to 1, 2 goes to 3, and 6 goes to 7.
- R6: With `rst` low and `load_en` high, the next edge writes `load_val` into `count`. This applies to any code, whatever `cnt_en` is. Reset takes priority over the preset, and the preset takes priority over counting.
- R7: `count` changes only at rising clock edges, because it is driven directly by the state flip-flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the value 1 |
| cnt_en | input | 1 | Advance one step per edge when high; hold when low |
| load_en | input | 1 | Synchronous preset strobe |
| load_val | input | 3 | Code written by the preset |
| count | output | 3 | Current state, which is also the output value |

## Verification
The stepping function is tried in several ways: a directed walk of the full cycle, including the 7 to 1 wrap; a preset to each of 0, 2 and 6 followed by one enabled edge; enable-low stretches; and collisions of reset with preset and of preset with enable. The directed walk separates a wrong successor from a wrong wrap. The unused-code presets separate correct recovery from a counter that recovers only because it was never placed in those codes. A seeded random mix of all controls then runs against a bench model of the cycle. This mix catches priority mistakes that only show up when several strobes are high on the same edge.

// File: rtl/seq_counter_pkg.sv
package seq_counter_pkg;
  localparam int unsigned CODE_W = 3;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t FIRST_CODE = code_t'(1);

  // Successor on the cycle; unused codes fold into the cycle member above them.
  function automatic code_t succ(input code_t c);
    code_t r;
    case (c)
      code_t'(0): r = code_t'(1);
      code_t'(1): r = code_t'(3);
      code_t'(2): r = code_t'(3);
      code_t'(3): r = code_t'(4);
      code_t'(4): r = code_t'(5);
      code_t'(5): r = code_t'(7);
      code_t'(6): r = code_t'(7);
      default:    r = code_t'(1);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/seq_next_logic.sv
module seq_next_logic
  import seq_counter_pkg::*;
(
  input  code_t cur,
  input  logic  adv,
  input  logic  pre,
  input  code_t pre_val,
  output code_t nxt
);
  always_comb begin
    if (pre)      nxt = pre_val;
    else if (adv) nxt = succ(cur);
    else          nxt = cur;
  end
endmodule

// File: rtl/seq_state_reg.sv
module seq_state_reg #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= INIT[i];
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/seq_counter.sv
module seq_counter
  import seq_counter_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              load_en,
  input  logic [CODE_W-1:0] load_val,
  output logic [CODE_W-1:0] count
);
  code_t state_q;
  code_t state_d;

  seq_next_logic u_next (
    .cur     (state_q),
    .adv     (cnt_en),
    .pre     (load_en),
    .pre_val (load_val),
    .nxt     (state_d)
  );

  seq_state_reg #(.W(CODE_W), .INIT(FIRST_CODE)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (state_d),
    .q   (state_q)
  );

  assign count = state_q;
endmodule

// File: rtl/seq_counter_chk.sv
module seq_counter_chk
  import seq_counter_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              load_en,
  input logic [CODE_W-1:0] load_val,
  input logic [CODE_W-1:0] count
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_reset_value_r1: assert property (@(posedge clk) armed && rst |=> count == 3'd1);

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    (!load_en && cnt_en && count == 3'd7) |=> count == 3'd1);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    (!load_en && !cnt_en) |=> $stable(count));

  p_legal_after_step_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    (!load_en && cnt_en) |=> (count != 3'd0 && count != 3'd2 && count != 3'd6));

  p_preset_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    load_en |=> count == $past(load_val));

  p_step_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    (!load_en && cnt_en && count == 3'd4) |=> count == 3'd5);
endmodule

bind seq_counter seq_counter_chk u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .load_en(load_en),
  .load_val(load_val), .count(count)
);

// File: tb/seq_counter_test.sv
`timescale 1ns/1ps
module seq_counter_test;
  localparam real HALF = 2.5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       load_en = 1'b0;
  logic [2:0] load_val = 3'd0;
  logic [2:0] count;
  logic [2:0] model = 3'd1;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(HALF) clk = ~clk;

  seq_counter uut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .load_en(load_en),
    .load_val(load_val), .count(count)
  );

  function automatic logic [2:0] ref_succ(input logic [2:0] c);
    case (c)
      3'd0, 3'd7: return 3'd1;
      3'd1, 3'd2: return 3'd3;
      3'd3:       return 3'd4;
      3'd4:       return 3'd5;
      default:    return 3'd7;
    endcase
  endfunction

  function automatic logic [2:0] ref_next(input logic [2:0] c, input logic r,
      input logic l, input logic [2:0] lv, input logic e);
    if (r) return 3'd1;
    if (l) return lv;
    if (e) return ref_succ(c);
    return c;
  endfunction

  task automatic check(input string tag, input logic [2:0] exp);
    checks++;
    if (count !== exp) begin
      failures++;
      $display("FAIL %s: count=%0d expected=%0d", tag, count, exp);
    end
  endtask

  // Drive on the falling edge, advance one rising edge, sample 1 ns later.
  task automatic step(input string tag, input logic r, input logic l,
      input logic [2:0] lv, input logic e);
    @(negedge clk);
    rst = r; load_en = l; load_val = lv; cnt_en = e;
    model = ref_next(model, r, l, lv, e);
    @(posedge clk);
    #1;
    check(tag, model);
    // R7: no change between edges
    #1;
    if (count !== model) begin
      checks++; failures++;
      $display("FAIL R7: count=%0d expected=%0d between edges", count, model);
    end
  endtask

  initial begin
    #(2.0 * HALF * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: count=%0d expected=finish", count);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    step("R1 reset", 1, 0, 3'd0, 0);
    step("R1 reset with enable", 1, 0, 3'd5, 1);
    // full cycle including wrap
    step("R2 1->3", 0, 0, 3'd0, 1);
    step("R2 3->4", 0, 0, 3'd0, 1);
    step("R2 4->5", 0, 0, 3'd0, 1);
    step("R2 5->7", 0, 0, 3'd0, 1);
    step("R3 7->1", 0, 0, 3'd0, 1);
    step("R2 1->3 again", 0, 0, 3'd0, 1);
    step("R4 hold", 0, 0, 3'd0, 0);
    step("R4 hold", 0, 0, 3'd6, 0);
    // unused codes
    step("R6 preset 0", 0, 1, 3'd0, 0);
    step("R5 0->1", 0, 0, 3'd0, 1);
    step("R6 preset 2", 0, 1, 3'd2, 1);
    step("R5 2->3", 0, 0, 3'd0, 1);
    step("R6 preset 6", 0, 1, 3'd6, 0);
    step("R4 hold unused 6", 0, 0, 3'd0, 0);
    step("R5 6->7", 0, 0, 3'd0, 1);
    step("R1 reset over preset", 1, 1, 3'd6, 1);
    step("R6 preset over enable", 0, 1, 3'd4, 1);
    step("R6 preset 7", 0, 1, 3'd7, 0);
    step("R3 wrap from preset", 0, 0, 3'd0, 1);
    for (int i = 0; i < 400; i++) begin
      logic r, l, e;
      logic [2:0] lv;
      r  = ($urandom % 16) == 0;
      l  = ($urandom % 5) == 0;
      e  = ($urandom % 3) != 0;
      lv = 3'($urandom);
      step("R2 R4 R5 R6 random", r, l, lv, e);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule